// File: doc/BRIEF.md
# Three-Mode Down-Counting Timer

This block is a down-counter, sixteen bits wide by default, loaded from a preset that software writes one byte at a time. It runs in one of three behaviours. As a periodic timer it reloads itself on reaching zero and toggles a square-wave output that can serve as a bit-rate clock. As a free-running counter it measures a delay and wraps through the all-ones value. As a receive watchdog it is started by incoming characters, not by software, and raises its flag when the incoming data stream pauses.

Counting advances only on cycles where the tick-enable input is high, so the tick source selects the counting rate. Every zero event raises a sticky flag meant for an interrupt status register and gives a one-cycle pulse. A read strobe captures the whole count into a snapshot register, so the upper and lower bytes always come from the same cycle.

Top module: `cntm_top`

## Requirements
- R1: After reset the flag, the pulse, the square-wave output, the snapshot, the count, both preset bytes and the mode bit are all zero. The block is idle and not in watchdog mode.
- R2: A write with `wr_addr`=0 loads the upper preset byte (bits 15:8). A write with `wr_addr`=1 loads the lower byte (bits 7:0). A write with `wr_addr`=2 sets the mode bit from `wr_data[0]` (0 = timer, 1 = counter). A preset write never alters a count that is already running. The new preset is used only at the next load or reload.
- R3: In timer mode (mode bit 0), `cmd_start` loads the preset and starts counting. On a tick where the count is 1 or 0, the preset is reloaded and `sq_out` toggles. Otherwise the count drops by one. With a preset of N≥1, a half period lasts N ticks.
- R4: Every zero event gives `zero_pulse` high for exactly the one cycle after the event edge and sets `irq_flag` at that same edge.
- R5: In counter mode (mode bit 1), the count drops by one on each tick and wraps from 0 to 0xFFFF. A zero event happens on the tick that moves the count from 1 to 0. `irq_flag` stays set until `cmd_stop`. `cmd_stop` halts counting and clears the flag. If `cmd_stop` and `cmd_start` arrive together, the stop wins.
- R6: `cmd_to_set` enters watchdog mode and halts the counter. In watchdog mode each `rx_char` strobe reloads the preset and starts counting. On a tick where the count is 1 or 0, the count becomes 0, counting halts, and a zero event occurs. The counter then waits for the next strobe.
- R7: In watchdog mode `cmd_start` has no effect. `cmd_stop` only clears `irq_flag` and leaves the count running.
- R8: Outside watchdog mode `rx_char` has no effect. `cmd_to_clr` leaves watchdog mode and halts the counter. If both watchdog commands arrive together, the clear wins.
- R9: On a cycle with `tick_en` low, a running count holds its value.
- R10: A `rd_snap` strobe captures the full count into `rd_val` at the same edge. Without a strobe, `rd_val` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 preset upper, 1 preset lower, 2 mode |
| wr_data | input | 8 | Write data |
| cmd_start | input | 1 | Start command (load preset, run) |
| cmd_stop | input | 1 | Stop command (halt, clear flag) |
| cmd_to_set | input | 1 | Enter receive watchdog mode |
| cmd_to_clr | input | 1 | Leave receive watchdog mode |
| rx_char | input | 1 | Received-character strobe |
| tick_en | input | 1 | Count enable for this cycle |
| rd_snap | input | 1 | Capture count into snapshot |
| rd_val | output | 16 | Captured count |
| irq_flag | output | 1 | Sticky zero-event flag |
| sq_out | output | 1 | Square-wave output (timer mode) |
| zero_pulse | output | 1 | One-cycle zero-event pulse |

## Verification
The timer mode is run with a small preset and ticks on every cycle, which shows the exact half period and the reload. It is then run with randomly gated ticks, which separates counting on ticks from counting on clocks. Counter mode is driven across the 1→0 step and into the wrap to 0xFFFF, which shows the difference between reloading and wrapping and shows that the flag stays set until a stop. Watchdog mode is fed strobes spaced both closer and wider than the preset, which shows that a restart pushes the zero event back and that a halt waits for the next strobe. Start, stop and strobes are also sent in modes where they must be ignored, and a preset is rewritten in the middle of a run.

// File: rtl/cntm_pkg.sv
package cntm_pkg;
   typedef enum logic {
      MODE_TIMER   = 1'b0,
      MODE_COUNTER = 1'b1
   } cntm_mode_e;
endpackage

// File: rtl/cntm_preset_regs.sv
module cntm_preset_regs
   import cntm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [CNT_W-1:0]  preset,
   output cntm_mode_e        mode
);
   localparam int NBYTES    = CNT_W / BYTE_W;
   localparam int MODE_ADDR = NBYTES;

   // byte lanes: lane i holds bits [i*BYTE_W +: BYTE_W], most significant lane at address 0
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      localparam int LANE_ADDR = NBYTES - 1 - i;
      logic [BYTE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(LANE_ADDR))) begin
            lane_q <= wr_data;
         end
      end
      assign preset[i*BYTE_W +: BYTE_W] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_TIMER;
      end else if (wr_en && (wr_addr == ADDR_W'(MODE_ADDR))) begin
         mode <= cntm_mode_e'(wr_data[0]);
      end
   end
endmodule

// File: rtl/cntm_core.sv
module cntm_core
   import cntm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic             stop,
   input  logic             to_set,
   input  logic             to_clr,
   input  logic             rx_char,
   input  logic [CNT_W-1:0] preset,
   input  cntm_mode_e       mode,
   output logic [CNT_W-1:0] cnt,
   output logic             run,
   output logic             to_act,
   output logic             flag,
   output logic             sq,
   output logic             zp
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;
   logic             run_q, to_q, flag_q, sq_q, zp_q;
   logic             at_le1, at_one, adv;

   assign cnt_dec = cnt_q - CNT_W'(1);
   assign at_le1  = (cnt_q[CNT_W-1:1] == '0);
   assign at_one  = (cnt_q == CNT_W'(1));
   assign adv     = run_q && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         to_q   <= 1'b0;
         flag_q <= 1'b0;
         sq_q   <= 1'b0;
         zp_q   <= 1'b0;
      end else begin
         zp_q <= 1'b0;
         if (to_clr) begin
            to_q  <= 1'b0;
            run_q <= 1'b0;
         end else if (to_set) begin
            to_q  <= 1'b1;
            run_q <= 1'b0;
         end else if (to_q) begin
            if (stop) flag_q <= 1'b0;
            if (rx_char) begin
               cnt_q <= preset;
               run_q <= 1'b1;
            end else if (adv) begin
               if (at_le1) begin
                  cnt_q  <= '0;
                  run_q  <= 1'b0;
                  flag_q <= 1'b1;
                  zp_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_dec;
               end
            end
         end else if (stop) begin
            run_q  <= 1'b0;
            flag_q <= 1'b0;
         end else if (start) begin
            cnt_q <= preset;
            run_q <= 1'b1;
         end else if (adv) begin
            if (mode == MODE_TIMER) begin
               if (at_le1) begin
                  cnt_q  <= preset;
                  sq_q   <= ~sq_q;
                  flag_q <= 1'b1;
                  zp_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_dec;
               end
            end else begin
               cnt_q <= cnt_dec;
               if (at_one) begin
                  flag_q <= 1'b1;
                  zp_q   <= 1'b1;
               end
            end
         end
      end
   end

   assign cnt    = cnt_q;
   assign run    = run_q;
   assign to_act = to_q;
   assign flag   = flag_q;
   assign sq     = sq_q;
   assign zp     = zp_q;
endmodule

// File: rtl/cntm_snap.sv
module cntm_snap #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] val
);
   localparam int NBYTES = CNT_W / BYTE_W;

   // every lane shares the one strobe so all bytes come from the same edge
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (rd) q <= cnt[i*BYTE_W +: BYTE_W];
      end
      assign val[i*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/cntm_top.sv
module cntm_top
   import cntm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              cmd_start,
   input  logic              cmd_stop,
   input  logic              cmd_to_set,
   input  logic              cmd_to_clr,
   input  logic              rx_char,
   input  logic              tick_en,
   input  logic              rd_snap,
   output logic [CNT_W-1:0]  rd_val,
   output logic              irq_flag,
   output logic              sq_out,
   output logic              zero_pulse
);
   localparam int NBYTES = CNT_W / BYTE_W;

   if (CNT_W % BYTE_W != 0) begin : g_bad_split
      $error("CNT_W must be a whole number of bytes");
   end
   if (NBYTES < 1) begin : g_bad_width
      $error("CNT_W must be at least one byte");
   end
   if ((1 << ADDR_W) < NBYTES + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for preset lanes plus mode");
   end

   logic [CNT_W-1:0] preset;
   cntm_mode_e       mode;
   logic [CNT_W-1:0] cnt;
   logic             run, to_act;

   cntm_preset_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .preset(preset), .mode(mode)
   );

   cntm_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .start(cmd_start),
      .stop(cmd_stop), .to_set(cmd_to_set), .to_clr(cmd_to_clr),
      .rx_char(rx_char), .preset(preset), .mode(mode), .cnt(cnt),
      .run(run), .to_act(to_act), .flag(irq_flag), .sq(sq_out),
      .zp(zero_pulse)
   );

   cntm_snap #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .rd(rd_snap), .cnt(cnt), .val(rd_val)
   );
endmodule

// File: rtl/cntm_chk.sv
module cntm_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_start,
   input logic             cmd_stop,
   input logic             cmd_to_set,
   input logic             cmd_to_clr,
   input logic             rx_char,
   input logic             tick_en,
   input logic             rd_snap,
   input logic [CNT_W-1:0] rd_val,
   input logic             irq_flag,
   input logic             sq_out,
   input logic             zero_pulse,
   input logic [CNT_W-1:0] cnt,
   input logic             run,
   input logic             to_act
);
   p_pulse_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      zero_pulse |-> irq_flag);

   p_sq_moves_on_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sq_out) |-> zero_pulse);

   p_stop_clears_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stop && !to_act && !cmd_to_set && !cmd_to_clr) |=> !irq_flag);

   p_watchdog_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (to_act && zero_pulse) |-> !run);

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (to_act && !run && cmd_start && !rx_char && !cmd_to_set && !cmd_to_clr) |=> !run);

   p_tick_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cmd_start && !cmd_to_set && !cmd_to_clr && !rx_char) |=> $stable(cnt));

   p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_snap |=> $stable(rd_val));
endmodule

bind cntm_top cntm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
   .cmd_to_set(cmd_to_set), .cmd_to_clr(cmd_to_clr), .rx_char(rx_char),
   .tick_en(tick_en), .rd_snap(rd_snap), .rd_val(rd_val),
   .irq_flag(irq_flag), .sq_out(sq_out), .zero_pulse(zero_pulse),
   .cnt(cnt), .run(run), .to_act(to_act)
);

// File: tb/cntm_top_tb.sv
module cntm_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 0;
   logic [1:0]  wr_addr = 0;
   logic [7:0]  wr_data = 0;
   logic        cmd_start = 0, cmd_stop = 0, cmd_to_set = 0, cmd_to_clr = 0;
   logic        rx_char = 0, tick_en = 0, rd_snap = 0;
   logic [15:0] rd_val;
   logic        irq_flag, sq_out, zero_pulse;

   int total = 0, bad = 0, cycles = 0;
   string cur_req = "R1";
   int tick_pat = 0;   // 0 off, 1 always, 2 random
   int snap_pat = 1;   // 0 off, 1 every cycle

   // reference model state
   int m_cnt = 0, m_pre = 0, m_snap = 0;
   bit m_run = 0, m_to = 0, m_flag = 0, m_sq = 0, m_zp = 0, m_ctr = 0;

   always #4 clk = ~clk;

   cntm_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cmd_to_set(cmd_to_set), .cmd_to_clr(cmd_to_clr), .rx_char(rx_char),
      .tick_en(tick_en), .rd_snap(rd_snap), .rd_val(rd_val),
      .irq_flag(irq_flag), .sq_out(sq_out), .zero_pulse(zero_pulse)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_snap = 0; m_run = 0; m_to = 0;
         m_flag = 0; m_sq = 0; m_zp = 0; m_ctr = 0;
      end else begin
         m_zp = 0;
         if (rd_snap) m_snap = m_cnt;
         if (cmd_to_clr) begin m_to = 0; m_run = 0; end
         else if (cmd_to_set) begin m_to = 1; m_run = 0; end
         else if (m_to) begin
            if (cmd_stop) m_flag = 0;
            if (rx_char) begin m_cnt = m_pre; m_run = 1; end
            else if (m_run && tick_en) begin
               if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_flag = 1; m_zp = 1; end
               else m_cnt = m_cnt - 1;
            end
         end else if (cmd_stop) begin m_run = 0; m_flag = 0; end
         else if (cmd_start) begin m_cnt = m_pre; m_run = 1; end
         else if (m_run && tick_en) begin
            if (!m_ctr) begin
               if (m_cnt <= 1) begin m_cnt = m_pre; m_sq = !m_sq; m_flag = 1; m_zp = 1; end
               else m_cnt = m_cnt - 1;
            end else begin
               if (m_cnt == 1) begin m_flag = 1; m_zp = 1; end
               m_cnt = (m_cnt + 65535) % 65536;
            end
         end
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_pre = (m_pre & 255) | (int'(wr_data) << 8);
               2'd1: m_pre = (m_pre & 65280) | int'(wr_data);
               2'd2: m_ctr = wr_data[0];
               default: ;
            endcase
         end
      end
   end

   // comparison every clock, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         total++;
         if (irq_flag !== m_flag || sq_out !== m_sq || zero_pulse !== m_zp ||
             int'(rd_val) != m_snap) begin
            bad++;
            $display("FAIL %s cyc=%0d flag=%b/%b sq=%b/%b zp=%b/%b val=%h/%h", cur_req, cycles,
                     irq_flag, m_flag, sq_out, m_sq, zero_pulse, m_zp, rd_val, m_snap[15:0]);
         end
      end
      if (cycles > 100000) begin
         bad++;
         $display("FAIL watchdog expired in %s", cur_req);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // pattern drivers for tick and snapshot strobe
   always @(negedge clk) begin
      tick_en <= (tick_pat == 1) ? 1'b1 : (tick_pat == 2) ? 1'($urandom_range(0, 1)) : 1'b0;
      rd_snap <= (snap_pat == 1);
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic pulse(int which);
      @(negedge clk);
      case (which)
         0: cmd_start = 1;
         1: cmd_stop = 1;
         2: cmd_to_set = 1;
         3: cmd_to_clr = 1;
         4: rx_char = 1;
         default: ;
      endcase
      @(negedge clk);
      cmd_start = 0; cmd_stop = 0; cmd_to_set = 0; cmd_to_clr = 0; rx_char = 0;
   endtask

   initial begin
      step(3);
      // R1: explicit reset-state check
      total++;
      if (irq_flag !== 0 || sq_out !== 0 || zero_pulse !== 0 || rd_val !== 16'h0) begin
         bad++;
         $display("FAIL R1 reset flag=%b sq=%b zp=%b val=%h expected all zero",
                  irq_flag, sq_out, zero_pulse, rd_val);
      end
      rst_n = 1;
      step(2);

      // R2 R3 R4: timer with preset 3, ticks every cycle
      cur_req = "R2/R3/R4 timer";
      wr(2'd0, 8'h00); wr(2'd1, 8'h03); wr(2'd2, 8'h00);
      tick_pat = 1;
      pulse(0);
      step(30);
      // R2: preset change mid-run
      cur_req = "R2 preset rewrite";
      wr(2'd1, 8'h05);
      step(30);
      // R9: gated ticks
      cur_req = "R9 random ticks";
      tick_pat = 2;
      step(60);
      tick_pat = 0;
      step(10);
      // R10: snapshot holds
      cur_req = "R10 snapshot hold";
      snap_pat = 0; tick_pat = 1;
      step(20);
      snap_pat = 1;
      step(3);
      pulse(1);

      // R5: counter mode, wrap and sticky flag
      cur_req = "R5 counter";
      wr(2'd1, 8'h04); wr(2'd2, 8'h01);
      pulse(0);
      step(25);
      @(negedge clk); cmd_stop = 1; cmd_start = 1;
      @(negedge clk); cmd_stop = 0; cmd_start = 0;
      step(5);
      pulse(0);
      step(8);
      pulse(1);
      step(4);

      // R8: rx ignored outside watchdog
      cur_req = "R8 rx outside watchdog";
      pulse(4);
      step(6);

      // R6 R7: watchdog mode
      cur_req = "R6 watchdog";
      wr(2'd1, 8'h06);
      pulse(2);
      step(4);
      pulse(4);
      step(3);
      pulse(4);       // restart before expiry
      step(12);       // expires and halts
      cur_req = "R7 start/stop in watchdog";
      pulse(0);
      step(5);
      pulse(1);       // clears flag only
      step(3);
      pulse(4);
      step(2);
      pulse(1);       // running count keeps going
      step(10);
      pulse(4);
      tick_pat = 2;
      step(30);
      tick_pat = 1;
      // R8: simultaneous set and clear, clear wins
      cur_req = "R8 mode exit";
      @(negedge clk); cmd_to_set = 1; cmd_to_clr = 1;
      @(negedge clk); cmd_to_set = 0; cmd_to_clr = 0;
      pulse(4);
      step(10);
      pulse(0);
      step(20);
      pulse(1);
      step(3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule